// File: doc/BRIEF.md
# Synchronous FIFO with Read Bypass

A single-clock first-in first-out queue whose storage is a RAM with a registered read port, the kind of read that on-chip block memories provide. The queue still presents look-ahead read data: while it is not empty, the oldest word is already on the read data output, and asserting the read enable retires it at the next clock edge.

A registered read port returns data one cycle after it is addressed. To hide that delay, the RAM is addressed with the read pointer the queue will hold after the current edge. The output register then always holds the word at the current head. This fails in one case: a write to the location that becomes the head in the same cycle, for example the first word written into an empty queue. The RAM then returns the old contents. A bypass register captures the write data on every clock, and a registered select flag steers it to the output for that one cycle.

A parameter picks the storage variant. One variant is the registered-read RAM with the bypass. The other is a plain array with a combinational read, for simulation. Both variants give the same port behaviour.

Top module: `sfifo_bypass`

## Requirements
- R1: While the synchronous reset is asserted and on the cycle after it is released, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were written. Whenever `empty` is 0, `rd_data` holds the oldest stored word with no added read latency, and a read retires it at the clock edge.
- R3: `empty` is 1 exactly when no words are stored. `full` is 1 exactly when DEPTH words are stored. The two are never 1 together.
- R4: A write while `full` is 1 is ignored. The occupancy and the stored words are unchanged, and `full` stays 1 unless a read happens in the same cycle.
- R5: A read while `empty` is 1 is ignored. No pointer moves, and a word written afterwards is read back correctly.
- R6: When a read and a write both take effect in the same cycle, the occupancy is unchanged.
- R7: A word written into an empty queue appears on `rd_data`, with `empty` at 0, on the cycle after the write edge.
- R8: A write to the location that becomes the head at the same edge (for example a read and a write with one word stored) shows the new word on `rd_data` in the next cycle. The stale RAM contents must not appear.
- R9: With SYNC_READ at 1 (registered-read RAM plus bypass) and at 0 (combinational-read array), all outputs are identical cycle for cycle whenever `empty` is 0. Flags are identical at all times.
- R10: Asserting reset while words are stored discards them. Both pointers and the bypass select are cleared, so `empty` reads 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Data to write |
| full | output | 1 | DEPTH words stored |
| rd_en | input | 1 | Read request (retire head word) |
| rd_data | output | DATA_W | Head word, valid while empty is 0 |
| empty | output | 1 | No words stored |

## Verification
The bench targets four corner cases.

- **Leaving the empty state.** A design that read the RAM with the current pointer, or that lacked the bypass, would show stale memory contents on the first cycle.
- **A single stored word read and replaced in one cycle.** The new word lands on the next head location. A missing select flag would expose the old contents.
- **Writes against a full queue and reads against an empty one.** An overflowing or underflowing design would corrupt order or flags.
- **Pointer wrap.** The bench runs long random traffic past many wraps, and keeps a combinational-read instance running alongside so that any divergence between the two variants shows up.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sfifo_ptr_ctl.sv
module sfifo_ptr_ctl #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] rd_idx,
   output logic [AW-1:0] rd_nxt_idx,
   output logic          full,
   output logic          empty
);
   localparam int PW = AW + 1;

   logic [PW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt, level;

   assign empty      = (wr_ptr == rd_ptr);
   assign full       = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
   assign wr_fire    = wr_en && !full;
   assign rd_fire    = rd_en && !empty;
   assign rd_ptr_nxt = rd_ptr + PW'(rd_fire);
   assign wr_idx     = wr_ptr[AW-1:0];
   assign rd_idx     = rd_ptr[AW-1:0];
   assign rd_nxt_idx = rd_ptr_nxt[AW-1:0];
   assign level      = wr_ptr - rd_ptr;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + PW'(1);
         rd_ptr <= rd_ptr_nxt;
      end
   end

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(empty && full)); // R3
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
      level <= PW'(DEPTH)); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en) |=> $stable(wr_ptr)); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (empty && rd_en) |=> $stable(rd_ptr)); // R5
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_fire && rd_fire) |=> (level == $past(level))); // R6
   AST_RESET_EMPTY: assert property (@(posedge clk)
      rst |=> empty); // R10
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 8,
   parameter bit SYNC_READ = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_fire,
   input  logic [AW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   input  logic [AW-1:0]     rd_nxt_idx,
   input  logic              empty,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_idx] <= wr_data;
   end

   if (SYNC_READ) begin : g_sync
      logic [DATA_W-1:0] ram_q, byp_q;
      logic              sel_q;

      always_ff @(posedge clk) begin
         ram_q <= mem[rd_nxt_idx];
         byp_q <= wr_data;
      end

      always_ff @(posedge clk) begin
         if (rst) sel_q <= 1'b0;
         else     sel_q <= wr_fire && (wr_idx == rd_nxt_idx);
      end

      assign rd_data = sel_q ? byp_q : ram_q;

      AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (rst)
         (wr_fire && (wr_idx == rd_nxt_idx)) |=> (rd_data == $past(wr_data))); // R8
      AST_HEAD_MATCH: assert property (@(posedge clk) disable iff (rst)
         !empty |-> (rd_data == mem[rd_idx])); // R9
   end else begin : g_comb
      assign rd_data = mem[rd_idx];
   end
endmodule

// File: rtl/sfifo_bypass.sv
module sfifo_bypass #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 8,
   parameter bit SYNC_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);
   localparam int AW = $clog2(DEPTH);

   if (!sfifo_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("sfifo_bypass: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sfifo_bypass: DATA_W must be at least 1");
   end

   logic          wr_fire, rd_fire;
   logic [AW-1:0] wr_idx, rd_idx, rd_nxt_idx;

   sfifo_ptr_ctl #(.DEPTH(DEPTH)) i_ctl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .wr_fire(wr_fire), .rd_fire(rd_fire),
      .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_nxt_idx(rd_nxt_idx),
      .full(full), .empty(empty)
   );

   sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_READ(SYNC_READ)) i_store (
      .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_nxt_idx(rd_nxt_idx),
      .empty(empty), .rd_data(rd_data)
   );

   AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
      rst |=> (empty && !full)); // R1
   AST_FILL_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (empty && wr_en) |=> !empty); // R7
endmodule

// File: tb/test_sfifo_bypass.sv
`timescale 1ns/1ps
module test_sfifo_bypass;
   localparam int DW = 16;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic full_a, empty_a, full_b, empty_b;
   logic [DW-1:0] rd_data_a, rd_data_b;

   sfifo_bypass #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_READ(1'b1)) i_sfifo_bypass (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_a),
      .rd_en(rd_en), .rd_data(rd_data_a), .empty(empty_a));

   sfifo_bypass #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_READ(1'b0)) i_sfifo_bypass_comb (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full_b),
      .rd_en(rd_en), .rd_data(rd_data_b), .empty(empty_b));

   int vectors = 0, miscompares = 0;
   logic [DW-1:0] mq [DEPTH];
   int mh = 0, mc = 0;

   task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      cmp({tag, " empty"}, DW'(empty_a), DW'(mc == 0));
      cmp({tag, " full"}, DW'(full_a), DW'(mc == DEPTH));
      if (mc > 0) cmp({tag, " data"}, rd_data_a, mq[mh]);
      cmp("R9 empty variant", DW'(empty_b), DW'(empty_a));
      cmp("R9 full variant", DW'(full_b), DW'(full_a));
      if (mc > 0) cmp("R9 data variant", rd_data_b, rd_data_a);
   endtask

   task automatic cycle(input logic we, input logic re, input logic [DW-1:0] wd, input string tag);
      bit wf, rf;
      wr_en = we; rd_en = re; wr_data = wd;
      @(posedge clk);
      wf = we && (mc < DEPTH);
      rf = re && (mc > 0);
      if (wf) mq[(mh + mc) % DEPTH] = wd;
      if (rf) mh = (mh + 1) % DEPTH;
      mc = mc + int'(wf) - int'(rf);
      #1;
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      cmp({tag, " empty in reset"}, DW'(empty_a), DW'(1));
      cmp({tag, " full in reset"}, DW'(full_a), DW'(0));
      rst = 1'b0; mh = 0; mc = 0;
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      #(5.0 * 150000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      do_reset("R1");

      // R5: read against empty, then a word must come back intact
      cycle(1'b0, 1'b1, 16'h0, "R5");
      cycle(1'b0, 1'b1, 16'h0, "R5");
      // R7: first word into empty shows on next cycle
      cycle(1'b1, 1'b0, 16'hA5A5, "R7");
      cycle(1'b0, 1'b1, 16'h0, "R5");
      // R8: one word stored, read and write together
      cycle(1'b1, 1'b0, 16'h1111, "R7");
      cycle(1'b1, 1'b1, 16'h2222, "R8");
      cycle(1'b1, 1'b1, 16'h3333, "R8");
      cycle(1'b0, 1'b1, 16'h0, "R2");
      // R7 with write and read asserted on empty queue
      cycle(1'b1, 1'b1, 16'h4444, "R7");
      cycle(1'b0, 1'b1, 16'h0, "R2");
      // R3/R4: fill, then push against full
      for (int i = 0; i < DEPTH; i++) cycle(1'b1, 1'b0, DW'(16'hB000 + i), "R3");
      cycle(1'b1, 1'b0, 16'hDEAD, "R4");
      cycle(1'b1, 1'b0, 16'hBEEF, "R4");
      // full with read and write: write blocked, occupancy drops
      cycle(1'b1, 1'b1, 16'hCAFE, "R4");
      // R6: simultaneous at mid occupancy
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, DW'(16'hC000 + i), "R6");
      // drain in order
      for (int i = 0; i < DEPTH; i++) cycle(1'b0, 1'b1, 16'h0, "R2");
      cycle(1'b0, 1'b1, 16'h0, "R5");
      // R10: reset with data stored
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, DW'(16'hE000 + i), "R2");
      do_reset("R10");
      cycle(1'b1, 1'b0, 16'h7777, "R7");
      cycle(1'b0, 1'b1, 16'h0, "R2");

      // random traffic with shifting bias
      for (int i = 0; i < 6000; i++) begin
         int wp, rp;
         case ((i / 500) % 4)
            0: begin wp = 70; rp = 30; end
            1: begin wp = 30; rp = 70; end
            2: begin wp = 50; rp = 50; end
            default: begin wp = 90; rp = 85; end
         endcase
         cycle(($urandom % 100) < wp, ($urandom % 100) < rp, DW'($urandom),
               (mc <= 1) ? "R8" : "R2");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule